// File: doc/BRIEF.md
# Multi-core local interrupt router

This block collects the interrupt sources of a four-core cluster and drives one normal interrupt line (IRQ) and one fast interrupt line (FIQ) into each core. Every core brings four timer interrupt levels and four mailbox-pending levels. Two shared upstream lines, one normal and one fast, come from a system-level controller. Each local source has its own pair of control bits: an IRQ enable and an FIQ select. The FIQ select takes priority over the enable. Each of the two shared lines is sent to a single core chosen by a routing register.

Software reaches the block through a simple 32-bit register port. A write strobe with address and data changes the control state on the clock edge. Read data follows the address combinationally. For every core the block computes an IRQ pending word and an FIQ pending word from the present levels and the present control bits. Both words are registered once per clock. A core's output line is the OR of its pending word. All sources are level-sensitive. A source that falls removes its pending bit on the next edge, so the block needs no acknowledge path.

Top module: `local_irq_router`

## Requirements
- R1: Offset 0x0C is the routing register. Bits [1:0] name the core that receives the shared IRQ and bits [3:2] name the core that receives the shared FIQ. It reads back as {fiqCore, irqCore} in bits [3:0], with all higher bits 0. Both fields reset to core 0.
- R2: Core c has an 8-bit timer control register at 0x40+4*c and an 8-bit mailbox control register at 0x50+4*c. In each, bit n (n = 0..3) enables IRQ delivery of source n and bit n+4 selects FIQ for that source. Written bits above bit 7 are dropped and read as 0. All control registers reset to 0.
- R3: An active source with its FIQ select set goes to FIQ only, whatever its IRQ enable holds. An active source with only the IRQ enable set goes to IRQ only. An active source with neither bit set reaches neither pending word.
- R4: In both pending words, timer sources 0..3 occupy bits 0..3, mailbox sources 0..3 occupy bits 4..7 and the shared upstream line occupies bit 8. Bits 9 to 31 always read 0.
- R5: The IRQ pending word of core c reads at 0x60+4*c and the FIQ pending word at 0x70+4*c. irqOut[c] is high exactly when the IRQ word of core c is nonzero, and fiqOut[c] is high exactly when the FIQ word of core c is nonzero.
- R6: The shared IRQ input sets bit 8 of the IRQ word of the routed IRQ core and of no other core. The shared FIQ input sets bit 8 of the FIQ word of the routed FIQ core and of no other core.
- R7: All source inputs are levels. A source that is low contributes nothing, so dropping a source clears its pending bit with no software action.
- R8: A read returns 0 at any offset other than those in R1, R2 and R5, including offsets whose two low bits are not 00. A write to any such offset changes nothing. A write to a pending-word offset also changes nothing.
- R9: A change on a source input, or a control write, appears in the pending words and on the output lines one clock edge after the pending logic sees it. A control write therefore reaches the outputs on the second edge after the write strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timerIrq | input | NUM_CORES*NUM_TIMERS | Timer levels; bit c*NUM_TIMERS+n is timer n of core c |
| mboxPend | input | NUM_CORES*NUM_MBOX | Mailbox-pending levels; bit c*NUM_MBOX+n is mailbox n of core c |
| upIrq | input | 1 | Shared upstream IRQ level |
| upFiq | input | 1 | Shared upstream FIQ level |
| regAddr | input | ADDR_W | Register byte offset |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| irqOut | output | NUM_CORES | Per-core IRQ line |
| fiqOut | output | NUM_CORES | Per-core FIQ line |

## Verification
The hardest case to reach from the ports is a core that carries the same upstream bit in both of its pending words while, on that same core, local sources with both control bits set are active. This needs the two routing fields to name the same core and the control bits and source levels to line up at the same time. Free-running random input levels are mixed with random writes to the routing and control offsets, so these overlaps occur without being planned. Directed steps then force the exact cases: FIQ select together with IRQ enable, the two upstream lines routed to different cores, and writes that land on pending, misaligned or unmapped offsets.

// File: rtl/lir_pkg.sv
package lir_pkg;

  // width of the read and write data words
  localparam int unsigned REG_W  = 32;
  // pending word: 4 timers, 4 mailboxes, shared line, 3 unused
  localparam int unsigned PEND_W = 12;

  // address regions, decoded from offset bits [7:4]
  localparam logic [3:0] RGN_GLOBAL  = 4'h0;
  localparam logic [3:0] RGN_TMRCTL  = 4'h4;
  localparam logic [3:0] RGN_MBXCTL  = 4'h5;
  localparam logic [3:0] RGN_IRQPEND = 4'h6;
  localparam logic [3:0] RGN_FIQPEND = 4'h7;
  // slot of the routing register inside the global region
  localparam logic [1:0] ROUTE_SLOT  = 2'd3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROUTE,
    SEL_TMRCTL,
    SEL_MBXCTL,
    SEL_IRQPEND,
    SEL_FIQPEND
  } regSel_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic    wrStb;
    regSel_e sel;
    logic [1:0] coreIdx;
  } regStrobe_t;

  // steer one active source: returns {toFiq, toIrq}
  function automatic logic [1:0] steerSource(input logic active,
                                             input logic irqEn,
                                             input logic fiqSel);
    logic [1:0] res;
    res[1] = active & fiqSel;
    res[0] = active & irqEn & ~fiqSel;
    return res;
  endfunction

endpackage

// File: rtl/lir_ctrl.sv
module lir_ctrl
  import lir_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_CORES = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobe
);

  logic       upperClear;
  logic [3:0] region;
  logic [1:0] slot;
  logic       aligned;
  logic       slotValid;
  regSel_e    sel;

  generate
    if (ADDR_W > 8) begin : g_upper
      assign upperClear = ~|regAddr[ADDR_W-1:8];
    end else begin : g_noUpper
      assign upperClear = 1'b1;
    end
  endgenerate

  assign region    = regAddr[7:4];
  assign slot      = regAddr[3:2];
  assign aligned   = (regAddr[1:0] == 2'b00);
  assign slotValid = (32'(slot) < NUM_CORES);

  always_comb begin
    sel = SEL_NONE;
    if (aligned && upperClear) begin
      case (region)
        RGN_GLOBAL:  if (slot == ROUTE_SLOT) sel = SEL_ROUTE;
        RGN_TMRCTL:  if (slotValid) sel = SEL_TMRCTL;
        RGN_MBXCTL:  if (slotValid) sel = SEL_MBXCTL;
        RGN_IRQPEND: if (slotValid) sel = SEL_IRQPEND;
        RGN_FIQPEND: if (slotValid) sel = SEL_FIQPEND;
        default:     sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strobe.sel     = sel;
    strobe.coreIdx = slot;
    // pending words are read-only: only control targets take writes
    strobe.wrStb   = regWrEn &&
                     ((sel == SEL_ROUTE) || (sel == SEL_TMRCTL) || (sel == SEL_MBXCTL));
  end

endmodule

// File: rtl/lir_core_route.sv
module lir_core_route
  import lir_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 4,
  parameter int unsigned NUM_MBOX   = 4
) (
  input  logic [NUM_TIMERS-1:0]   tmrAct,
  input  logic [2*NUM_TIMERS-1:0] tmrCtl,
  input  logic [NUM_MBOX-1:0]     mbxAct,
  input  logic [2*NUM_MBOX-1:0]   mbxCtl,
  input  logic                    upIrqHit,
  input  logic                    upFiqHit,
  output logic [PEND_W-1:0]       irqNext,
  output logic [PEND_W-1:0]       fiqNext
);

  localparam int unsigned MBX_BASE = NUM_TIMERS;
  localparam int unsigned UP_BIT   = NUM_TIMERS + NUM_MBOX;

  generate
    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
      logic [1:0] steer;
      assign steer      = steerSource(tmrAct[t], tmrCtl[t], tmrCtl[t+NUM_TIMERS]);
      assign irqNext[t] = steer[0];
      assign fiqNext[t] = steer[1];
    end

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbx
      logic [1:0] steer;
      assign steer                 = steerSource(mbxAct[m], mbxCtl[m], mbxCtl[m+NUM_MBOX]);
      assign irqNext[MBX_BASE + m] = steer[0];
      assign fiqNext[MBX_BASE + m] = steer[1];
    end

    for (genvar r = UP_BIT + 1; r < PEND_W; r++) begin : g_rsvd
      assign irqNext[r] = 1'b0;
      assign fiqNext[r] = 1'b0;
    end
  endgenerate

  assign irqNext[UP_BIT] = upIrqHit;
  assign fiqNext[UP_BIT] = upFiqHit;

endmodule

// File: rtl/lir_datapath.sv
module lir_datapath
  import lir_pkg::*;
#(
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned NUM_TIMERS = 4,
  parameter int unsigned NUM_MBOX   = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  regStrobe_t                      strobe,
  input  logic [REG_W-1:0]                wrData,
  input  logic [NUM_CORES*NUM_TIMERS-1:0] timerIrq,
  input  logic [NUM_CORES*NUM_MBOX-1:0]   mboxPend,
  input  logic                            upIrq,
  input  logic                            upFiq,
  output logic [REG_W-1:0]                rdData,
  output logic [NUM_CORES-1:0]            irqOut,
  output logic [NUM_CORES-1:0]            fiqOut
);

  localparam int unsigned CTL_T  = 2 * NUM_TIMERS;
  localparam int unsigned CTL_M  = 2 * NUM_MBOX;
  localparam int unsigned UP_BIT = NUM_TIMERS + NUM_MBOX;

  logic [1:0]        routeIrq;
  logic [1:0]        routeFiq;
  logic [CTL_T-1:0]  tmrCtl   [NUM_CORES];
  logic [CTL_M-1:0]  mbxCtl   [NUM_CORES];
  logic [PEND_W-1:0] irqPendQ [NUM_CORES];
  logic [PEND_W-1:0] fiqPendQ [NUM_CORES];
  logic [PEND_W-1:0] irqNext  [NUM_CORES];
  logic [PEND_W-1:0] fiqNext  [NUM_CORES];

  // routing register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routeIrq <= '0;
      routeFiq <= '0;
    end else if (strobe.wrStb && (strobe.sel == SEL_ROUTE)) begin
      routeIrq <= wrData[1:0];
      routeFiq <= wrData[3:2];
    end
  end

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      localparam logic [1:0] C_ID = 2'(c);
      logic wrTmr;
      logic wrMbx;

      assign wrTmr = strobe.wrStb && (strobe.sel == SEL_TMRCTL) && (strobe.coreIdx == C_ID);
      assign wrMbx = strobe.wrStb && (strobe.sel == SEL_MBXCTL) && (strobe.coreIdx == C_ID);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          tmrCtl[c] <= '0;
          mbxCtl[c] <= '0;
        end else begin
          if (wrTmr) tmrCtl[c] <= wrData[CTL_T-1:0];
          if (wrMbx) mbxCtl[c] <= wrData[CTL_M-1:0];
        end
      end

      lir_core_route #(
        .NUM_TIMERS (NUM_TIMERS),
        .NUM_MBOX   (NUM_MBOX)
      ) u_route (
        .tmrAct   (timerIrq[c*NUM_TIMERS +: NUM_TIMERS]),
        .tmrCtl   (tmrCtl[c]),
        .mbxAct   (mboxPend[c*NUM_MBOX +: NUM_MBOX]),
        .mbxCtl   (mbxCtl[c]),
        .upIrqHit (upIrq && (routeIrq == C_ID)),
        .upFiqHit (upFiq && (routeFiq == C_ID)),
        .irqNext  (irqNext[c]),
        .fiqNext  (fiqNext[c])
      );

      // single register stage: fixed one-edge latency
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          irqPendQ[c] <= '0;
          fiqPendQ[c] <= '0;
        end else begin
          irqPendQ[c] <= irqNext[c];
          fiqPendQ[c] <= fiqNext[c];
        end
      end

      assign irqOut[c] = |irqPendQ[c];
      assign fiqOut[c] = |fiqPendQ[c];

      for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_chk
        // R3: FIQ select outranks the IRQ enable
        p_fiq_select_r3: assert property (@(posedge clk) disable iff (!rstN)
          (timerIrq[c*NUM_TIMERS+t] && tmrCtl[c][t+NUM_TIMERS])
          |=> (fiqPendQ[c][t] && !irqPendQ[c][t]))
          else $error("p_fiq_select_r3 core %0d src %0d", c, t);

        p_irq_only_r3: assert property (@(posedge clk) disable iff (!rstN)
          (timerIrq[c*NUM_TIMERS+t] && tmrCtl[c][t] && !tmrCtl[c][t+NUM_TIMERS])
          |=> (irqPendQ[c][t] && !fiqPendQ[c][t]))
          else $error("p_irq_only_r3 core %0d src %0d", c, t);

        p_masked_r3: assert property (@(posedge clk) disable iff (!rstN)
          (!tmrCtl[c][t] && !tmrCtl[c][t+NUM_TIMERS])
          |=> (!irqPendQ[c][t] && !fiqPendQ[c][t]))
          else $error("p_masked_r3 core %0d src %0d", c, t);

        // R7: a low level leaves nothing behind
        p_level_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
          !timerIrq[c*NUM_TIMERS+t] |=> (!irqPendQ[c][t] && !fiqPendQ[c][t]))
          else $error("p_level_clear_r7 core %0d src %0d", c, t);
      end

      // R6: shared lines reach only their routed core
      p_up_irq_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
        (upIrq && (routeIrq == C_ID)) |=> irqPendQ[c][UP_BIT])
        else $error("p_up_irq_hit_r6 core %0d", c);

      p_up_irq_miss_r6: assert property (@(posedge clk) disable iff (!rstN)
        (!upIrq || (routeIrq != C_ID)) |=> !irqPendQ[c][UP_BIT])
        else $error("p_up_irq_miss_r6 core %0d", c);

      p_up_fiq_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
        (upFiq && (routeFiq == C_ID)) |=> fiqPendQ[c][UP_BIT])
        else $error("p_up_fiq_hit_r6 core %0d", c);

      p_up_fiq_miss_r6: assert property (@(posedge clk) disable iff (!rstN)
        (!upFiq || (routeFiq != C_ID)) |=> !fiqPendQ[c][UP_BIT])
        else $error("p_up_fiq_miss_r6 core %0d", c);
    end
  endgenerate

  // read multiplexer
  always_comb begin
    rdData = '0;
    case (strobe.sel)
      SEL_ROUTE: rdData[3:0] = {routeFiq, routeIrq};
      SEL_TMRCTL: begin
        for (int c = 0; c < NUM_CORES; c++)
          if (strobe.coreIdx == 2'(c)) rdData[CTL_T-1:0] = tmrCtl[c];
      end
      SEL_MBXCTL: begin
        for (int c = 0; c < NUM_CORES; c++)
          if (strobe.coreIdx == 2'(c)) rdData[CTL_M-1:0] = mbxCtl[c];
      end
      SEL_IRQPEND: begin
        for (int c = 0; c < NUM_CORES; c++)
          if (strobe.coreIdx == 2'(c)) rdData[PEND_W-1:0] = irqPendQ[c];
      end
      SEL_FIQPEND: begin
        for (int c = 0; c < NUM_CORES; c++)
          if (strobe.coreIdx == 2'(c)) rdData[PEND_W-1:0] = fiqPendQ[c];
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/local_irq_router.sv
module local_irq_router
  import lir_pkg::*;
#(
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned NUM_TIMERS = 4,
  parameter int unsigned NUM_MBOX   = 4,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_CORES*NUM_TIMERS-1:0] timerIrq,
  input  logic [NUM_CORES*NUM_MBOX-1:0]   mboxPend,
  input  logic                            upIrq,
  input  logic                            upFiq,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic                            regWrEn,
  input  logic [31:0]                     regWrData,
  output logic [31:0]                     regRdData,
  output logic [NUM_CORES-1:0]            irqOut,
  output logic [NUM_CORES-1:0]            fiqOut
);

  regStrobe_t ctrlStrobe;

  lir_ctrl #(
    .ADDR_W    (ADDR_W),
    .NUM_CORES (NUM_CORES)
  ) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (ctrlStrobe)
  );

  lir_datapath #(
    .NUM_CORES  (NUM_CORES),
    .NUM_TIMERS (NUM_TIMERS),
    .NUM_MBOX   (NUM_MBOX)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (ctrlStrobe),
    .wrData   (regWrData),
    .timerIrq (timerIrq),
    .mboxPend (mboxPend),
    .upIrq    (upIrq),
    .upFiq    (upFiq),
    .rdData   (regRdData),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut)
  );

  // R8: offsets the decoder rejects read back as zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStrobe.sel == SEL_NONE) |-> (regRdData == 32'd0))
    else $error("p_unmapped_zero_r8");

endmodule

// File: tb/tb_local_irq_router.sv
module tb_local_irq_router;

  localparam int NC = 4;
  localparam int NT = 4;
  localparam int NM = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] tmrIn;
  logic [15:0] mbxIn;
  logic        upIrqIn;
  logic        upFiqIn;
  logic [7:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [3:0]  irqOut;
  logic [3:0]  fiqOut;

  logic [1:0] mRouteIrq;
  logic [1:0] mRouteFiq;
  logic [7:0] mTmr [NC];
  logic [7:0] mMbx [NC];

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  local_irq_router #(
    .NUM_CORES (NC), .NUM_TIMERS (NT), .NUM_MBOX (NM), .ADDR_W (8)
  ) dut (
    .clk (clk), .rstN (rstN), .timerIrq (tmrIn), .mboxPend (mbxIn),
    .upIrq (upIrqIn), .upFiq (upFiqIn), .regAddr (regAddr), .regWrEn (regWrEn),
    .regWrData (regWrData), .regRdData (regRdData), .irqOut (irqOut), .fiqOut (fiqOut)
  );

  // expected pending word from R3, R4, R6, R7
  function automatic logic [31:0] expPend(int c, bit fiqSide);
    logic [31:0] v;
    v = '0;
    for (int j = 0; j < 4; j++) begin
      if (tmrIn[c*4+j]) begin
        if (mTmr[c][j+4]) begin
          if (fiqSide) v[j] = 1'b1;
        end else if (mTmr[c][j] && !fiqSide) v[j] = 1'b1;
      end
      if (mbxIn[c*4+j]) begin
        if (mMbx[c][j+4]) begin
          if (fiqSide) v[4+j] = 1'b1;
        end else if (mMbx[c][j] && !fiqSide) v[4+j] = 1'b1;
      end
    end
    if (!fiqSide && upIrqIn && int'(mRouteIrq) == c) v[8] = 1'b1;
    if (fiqSide && upFiqIn && int'(mRouteFiq) == c) v[8] = 1'b1;
    return v;
  endfunction

  // expected read data from R1, R2, R5, R8
  function automatic logic [31:0] expRead(logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'd0;
    case (a[7:4])
      4'h0: return (a[3:2] == 2'd3) ? {28'd0, mRouteFiq, mRouteIrq} : 32'd0;
      4'h4: return {24'd0, mTmr[a[3:2]]};
      4'h5: return {24'd0, mMbx[a[3:2]]};
      4'h6: return expPend(int'(a[3:2]), 1'b0);
      4'h7: return expPend(int'(a[3:2]), 1'b1);
      default: return 32'd0;
    endcase
  endfunction

  task automatic modelWrite(logic [7:0] a, logic [31:0] d);
    if (a[1:0] == 2'b00) begin
      if (a == 8'h0C) begin
        mRouteIrq = d[1:0];
        mRouteFiq = d[3:2];
      end else if (a[7:4] == 4'h4) mTmr[a[3:2]] = d[7:0];
      else if (a[7:4] == 4'h5) mMbx[a[3:2]] = d[7:0];
    end
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic readReg(logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // write, then let the pending stage see the new control (R9)
  task automatic writeReg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr   = a;
    regWrData = d;
    regWrEn   = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    modelWrite(a, d);
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkAll(string tag);
    logic [31:0] d;
    for (int c = 0; c < NC; c++) begin
      readReg(8'h60 + 8'(4*c), d);
      chk("R5", $sformatf("%s irq word core %0d", tag, c), d, expPend(c, 1'b0));
      readReg(8'h70 + 8'(4*c), d);
      chk("R5", $sformatf("%s fiq word core %0d", tag, c), d, expPend(c, 1'b1));
      chk("R5", $sformatf("%s irqOut core %0d", tag, c), 32'(irqOut[c]), 32'(expPend(c, 1'b0) != 0));
      chk("R5", $sformatf("%s fiqOut core %0d", tag, c), 32'(fiqOut[c]), 32'(expPend(c, 1'b1) != 0));
      readReg(8'h40 + 8'(4*c), d);
      chk("R2", $sformatf("%s timer ctl core %0d", tag, c), d, {24'd0, mTmr[c]});
      readReg(8'h50 + 8'(4*c), d);
      chk("R2", $sformatf("%s mbox ctl core %0d", tag, c), d, {24'd0, mMbx[c]});
    end
    readReg(8'h0C, d);
    chk("R1", {tag, " route"}, d, {28'd0, mRouteFiq, mRouteIrq});
  endtask

  function automatic logic [7:0] pickAddr();
    case ($urandom % 6)
      0: return 8'h0C;
      1: return 8'h40 + 8'(4 * ($urandom % 4));
      2: return 8'h50 + 8'(4 * ($urandom % 4));
      3: return 8'h60 + 8'(4 * ($urandom % 4));
      4: return 8'h70 + 8'(4 * ($urandom % 4));
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int unsigned seedInit;
    seedInit = $urandom(32'h5EED_0042);
    rstN = 1'b0; tmrIn = '0; mbxIn = '0; upIrqIn = 1'b0; upFiqIn = 1'b0;
    regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    mRouteIrq = '0; mRouteFiq = '0;
    for (int c = 0; c < NC; c++) begin mTmr[c] = '0; mMbx[c] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state: R1, R2, R5
    checkAll("reset");

    // R3 / R2: both bits on src0, FIQ only on src1, upper bits dropped
    tmrIn = 16'h00FF;
    writeReg(8'h40, 32'hFFFF_FF31);
    readReg(8'h40, d);
    chk("R2", "upper bits dropped", d, 32'h0000_0031);
    readReg(8'h70, d);
    chk("R3", "fiq select wins core0", d, 32'h0000_0003);
    readReg(8'h60, d);
    chk("R3", "no irq when fiq selected core0", d, 32'h0);
    writeReg(8'h44, 32'h0000_000C);
    readReg(8'h64, d);
    chk("R3", "irq enable only core1", d, 32'h0000_000C);
    readReg(8'h74, d);
    chk("R3", "masked src core1 fiq", d, 32'h0);

    // R4: mailbox bits 4..7
    mbxIn = 16'h0F00;
    writeReg(8'h58, 32'h0000_00F0);
    readReg(8'h78, d);
    chk("R4", "mailbox bits core2", d, 32'h0000_00F0);

    // R6 / R1: IRQ to core2, FIQ to core1
    writeReg(8'h0C, 32'hFFFF_FFE6);
    readReg(8'h0C, d);
    chk("R1", "route readback", d, 32'h0000_0006);
    upIrqIn = 1'b1; upFiqIn = 1'b1;
    settle();
    readReg(8'h68, d);
    chk("R6", "shared irq on core2", d[8] ? 32'd1 : 32'd0, 32'd1);
    readReg(8'h60, d);
    chk("R6", "shared irq not on core0", d[8] ? 32'd1 : 32'd0, 32'd0);
    readReg(8'h74, d);
    chk("R6", "shared fiq on core1", d[8] ? 32'd1 : 32'd0, 32'd1);
    readReg(8'h78, d);
    chk("R4", "core2 fiq word with reserved bits", d, 32'h0000_00F0);
    checkAll("upstream");

    // R7: levels drop, bits clear
    tmrIn = '0; mbxIn = '0; upIrqIn = 1'b0; upFiqIn = 1'b0;
    settle();
    checkAll("drop");
    chk("R7", "all irq lines low", 32'(irqOut), 32'd0);
    chk("R7", "all fiq lines low", 32'(fiqOut), 32'd0);

    // R8: ignored writes and unmapped reads
    writeReg(8'h60, 32'hFFFF_FFFF);
    writeReg(8'h41, 32'h0000_00FF);
    writeReg(8'h80, 32'h0000_00FF);
    writeReg(8'h0D, 32'h0000_000F);
    readReg(8'h40, d);
    chk("R8", "misaligned write ignored", d, 32'h0000_0031);
    readReg(8'h0C, d);
    chk("R8", "misaligned route write ignored", d, 32'h0000_0006);
    readReg(8'h60, d);
    chk("R8", "pending write ignored", d, 32'h0);
    readReg(8'h10, d);
    chk("R8", "unmapped read 0x10", d, 32'h0);
    readReg(8'h4D, d);
    chk("R8", "misaligned read 0x4D", d, 32'h0);
    readReg(8'hC0, d);
    chk("R8", "unmapped read 0xC0", d, 32'h0);

    // R9: one-edge latency from a source change
    writeReg(8'h4C, 32'h0000_0001);
    @(negedge clk);
    tmrIn[12] = 1'b1;
    #5;
    chk("R9", "before edge", 32'(irqOut[3]), 32'd0);
    @(negedge clk);
    chk("R9", "after one edge", 32'(irqOut[3]), 32'd1);
    tmrIn[12] = 1'b0;
    #5;
    chk("R9", "still high before edge", 32'(irqOut[3]), 32'd1);
    @(negedge clk);
    chk("R9", "low after one edge", 32'(irqOut[3]), 32'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      tmrIn   = 16'($urandom);
      mbxIn   = 16'($urandom);
      upIrqIn = 1'($urandom);
      upFiqIn = 1'($urandom);
      if ($urandom % 3 != 0) writeReg(pickAddr(), $urandom);
      else settle();
      checkAll("random");
      begin
        logic [7:0] a;
        a = 8'($urandom);
        readReg(a, d);
        chk("R8", $sformatf("random read %h", a), d, expRead(a));
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule